// File: doc/BRIEF.md
# Serial PHY Management Command Engine

This block lets a host read and write the 16-bit registers of an external Ethernet PHY over the two-wire management bus. One output is the management clock. The other wire is a shared, bidirectional data line, presented as an output value, an output enable and an input. The host sees two 32-bit registers. The command register is at offset 0x14 and the data register is at offset 0x18. To write a PHY register, the host first loads the data register and then writes the command register. To read one, the host writes only the command register. That single command write latches the PHY address, the register number and the direction, raises the busy flag and starts the serial frame.

The frame is generated by a state machine with five states. ST_IDLE leaves on a command write and goes to ST_PRE, which sends 32 ones. ST_PRE goes to ST_HDR after bit 31. ST_HDR sends the start pattern, the opcode and the two addresses, and goes to ST_TA after bit 45. ST_TA covers the two turnaround bits and goes to ST_DATA after bit 47. ST_DATA covers the 16 data bits and returns to ST_IDLE after bit 63. All of these moves happen on the falling-edge tick of the divided clock. During a read, the data line is released from the turnaround onward, and the PHY's bits are shifted in on rising management-clock edges. At completion the result is placed in the data register in the same cycle that busy clears. A host that polls busy therefore always finds valid data.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write to offset 0x14 while idle makes command bit 0 (busy) read 1 from the next cycle. Busy stays 1 for exactly 64*DIV cycles and then reads 0.
- R2: Each transaction puts 64 bits on the line, most significant first, in this order: 32 ones, start 01, opcode (10 read, 01 write), PHY address taken from command bits 15:11, register number taken from command bits 10:6, turnaround 10, then 16 data bits.
- R3: The data line output and its enable change only while the management clock is low. They hold steady for the whole high phase.
- R4: The management clock is the system clock divided by the even parameter DIV. The default of 80 gives 2.5 MHz from 200 MHz. The clock has exactly 64 rising edges per transaction, a high phase of DIV/2 cycles, and rests low when idle.
- R5: During a read, the output enable is 0 for bits 46 to 63 and 1 for all other bits. The 16 data bits are sampled on management-clock rising edges, most significant bit first.
- R6: When a read completes, data register bits 15:0 hold the sampled value, starting from the cycle in which busy reads 0.
- R7: A write sends data register bits 15:0, as loaded before the command. After a write, the data register keeps that value.
- R8: A command write that arrives while busy is 1 is ignored. The frame in progress and the command readback are both unchanged.
- R9: After reset, both registers read 0, the management clock is low and the output enable is 0.
- R10: The command register reads back the PHY address in bits 15:11, the register number in bits 10:6, the write select in bit 1 and busy in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (0x14 command, 0x18 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A wrong state or a wrong bit counter shows up at the ports as a frame that is shifted or truncated. It can also appear as a busy window that is a multiple of DIV cycles off. Either fault is visible within one transaction, 64*DIV cycles, after the command write. A wrong enable timing or a wrong sampling edge corrupts the read value captured in the data register, and that value can be read as soon as busy clears. A command that slips through while busy alters either the captured line pattern or the command readback of the same transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [7:0] OFS_CMD  = 8'h14;
    localparam logic [7:0] OFS_DATA = 8'h18;

    localparam int FRAME_BITS = 64;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;

    // last bit index of each frame section
    localparam logic [BIT_W-1:0] PRE_LAST  = BIT_W'(31);
    localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(45);
    localparam logic [BIT_W-1:0] TA_LAST   = BIT_W'(47);
    localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(63);

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic          mdc_q;

    assign rise_evt = run && (cnt == CW'(HALF - 1));
    assign fall_evt = run && (cnt == CW'(DIV - 1));
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else begin
            if (fall_evt) cnt <= '0;
            else          cnt <= cnt + 1'b1;
            if (rise_evt)      mdc_q <= 1'b1;
            else if (fall_evt) mdc_q <= 1'b0;
        end
    end

    // R4
    mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q && !$past(mdc_q)) |-> (cnt == CW'(HALF)));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_result,
    output logic              launch,
    output logic [DATA_W-1:0] data_q,
    output logic [31:0]       reg_rdata
);
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic              wr_q;

    assign launch = reg_wr && (reg_addr == OFS_CMD) && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
            wr_q  <= 1'b0;
        end else if (launch) begin
            phy_q <= reg_wdata[15:11];
            reg_q <= reg_wdata[10:6];
            wr_q  <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (done && !wr_q)
            data_q <= rd_result;
        else if (reg_wr && reg_addr == OFS_DATA)
            data_q <= reg_wdata[DATA_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = {16'h0, phy_q, reg_q, 4'h0, wr_q, busy};
            OFS_DATA: reg_rdata = {16'h0, data_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R8
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CMD && busy)
        |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));

endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] l_phy,
    input  logic [ADDR_W-1:0] l_reg,
    input  logic              l_wr,
    input  logic [DATA_W-1:0] l_data,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_result
);
    mdio_state_e            state, nxt;
    logic [FRAME_BITS-1:0]  tx_sr;
    logic [BIT_W-1:0]       bitcnt;
    logic                   op_wr;
    logic [DATA_W-1:0]      rx_sr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch)                          nxt = ST_PRE;
            ST_PRE:  if (fall_evt && bitcnt == PRE_LAST)  nxt = ST_HDR;
            ST_HDR:  if (fall_evt && bitcnt == HDR_LAST)  nxt = ST_TA;
            ST_TA:   if (fall_evt && bitcnt == TA_LAST)   nxt = ST_DATA;
            ST_DATA: if (fall_evt && bitcnt == DATA_LAST) nxt = ST_IDLE;
            default:                                      nxt = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            bitcnt <= '0;
            op_wr  <= 1'b0;
            rx_sr  <= '0;
        end else if (state == ST_IDLE) begin
            if (launch) begin
                tx_sr  <= {32'hFFFF_FFFF, 2'b01, (l_wr ? 2'b01 : 2'b10),
                           l_phy, l_reg, 2'b10, (l_wr ? l_data : 16'h0)};
                bitcnt <= '0;
                op_wr  <= l_wr;
            end
        end else begin
            if (fall_evt) begin
                tx_sr  <= {tx_sr[FRAME_BITS-2:0], 1'b1};
                bitcnt <= bitcnt + 1'b1;
            end
            if (rise_evt && state == ST_DATA && !op_wr)
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = fall_evt && (state == ST_DATA) && (bitcnt == DATA_LAST);
        mdio_o    = busy && tx_sr[FRAME_BITS-1];
        mdio_oe   = busy && !(!op_wr && (state == ST_TA || state == ST_DATA));
        rd_result = rx_sr;
    end

    // R2
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && nxt == ST_IDLE) |-> (bitcnt == DATA_LAST));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy, done, launch, rise_evt, fall_evt;
    logic [DATA_W-1:0] data_q, rd_result;

    mdio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done      (done),
        .rd_result (rd_result),
        .launch    (launch),
        .data_q    (data_q),
        .reg_rdata (reg_rdata)
    );

    mdio_clkdiv #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .l_phy     (reg_wdata[15:11]),
        .l_reg     (reg_wdata[10:6]),
        .l_wr      (reg_wdata[1]),
        .l_data    (data_q),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_result (rd_result)
    );

    // R1
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CMD && !reg_rdata[0] && !$isunknown(reg_wdata))
        |=> busy);

    // R4
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);

    // R3
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
    localparam int DIV = 4;
    localparam int FB  = 64;
    localparam logic [7:0] A_CMD  = 8'h14;
    localparam logic [7:0] A_DATA = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int vec = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and line capture
    wire         line = mdio_oe ? mdio_o : mdio_i;
    logic [63:0] line_cap = '0;
    logic [63:0] oe_cap = '0;
    int          rise_cnt = 0;
    int          base = 0;
    logic [15:0] phy_rd = '0;

    always @(posedge mdc) begin
        line_cap <= {line_cap[62:0], line};
        oe_cap   <= {oe_cap[62:0], mdio_oe};
        rise_cnt <= rise_cnt + 1;
    end

    always @(negedge mdc) begin
        int k;
        k = rise_cnt - base;
        if (k == 47)                mdio_i <= 1'b0;
        else if (k >= 48 && k < 64) mdio_i <= phy_rd[63 - k];
        else                        mdio_i <= 1'b1;
    end

    // R3 / R4 line monitors
    logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
    int   hold_viol = 0;
    int   hi_cnt = 0;
    always @(negedge clk) begin
        if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
            hold_viol <= hold_viol + 1;
        if (mdc) hi_cnt <= hi_cnt + 1;
        prev_mdc <= mdc;
        prev_o   <= mdio_o;
        prev_oe  <= mdio_oe;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic txn(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] rv, input logic rogue);
        logic [31:0] r;
        logic [63:0] ef, eo;
        int cyc, hi0;
        if (wr) wr_reg(A_DATA, {16'h0, wd});
        phy_rd = rv;
        base = rise_cnt;
        hi0 = hi_cnt;
        wr_reg(A_CMD, {16'h0, phy, ra, 4'h0, wr, 1'b0});
        rd_reg(A_CMD, r);
        chk("R1 busy set after command", 64'(r[0]), 64'd1);
        cyc = 0;
        while (r[0]) begin
            if (rogue && cyc == 100) begin
                reg_wr = 1'b1;
                reg_wdata = {16'h0, ~phy, ~ra, 4'h0, ~wr, 1'b0};
            end else begin
                reg_wr = 1'b0;
            end
            cyc++;
            @(negedge clk);
            rd_reg(A_CMD, r);
            if (cyc > FB * DIV + 50) break;
        end
        reg_wr = 1'b0;
        chk("R1 busy duration", 64'(cyc), 64'(FB * DIV));
        chk("R4 rising edges per frame", 64'(rise_cnt - base), 64'(FB));
        chk("R4 high phase total", 64'(hi_cnt - hi0), 64'(FB * DIV / 2));
        ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, (wr ? wd : rv)};
        chk(wr ? "R2 R7 R8 write frame" : "R2 R5 R8 read frame", line_cap, ef);
        eo = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
        chk("R5 output enable pattern", oe_cap, eo);
        chk("R10 R8 command readback", 64'(r), 64'({16'h0, phy, ra, 4'h0, wr, 1'b0}));
        rd_reg(A_DATA, r);
        chk(wr ? "R7 data register kept" : "R6 read result", 64'(r), 64'({16'h0, wr ? wd : rv}));
        chk("R4 idle clock low", 64'({mdc, mdio_oe}), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vec++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(A_CMD, r);
        chk("R9 reset command reg", 64'(r), 64'd0);
        rd_reg(A_DATA, r);
        chk("R9 reset data reg", 64'(r), 64'd0);
        chk("R9 reset line", 64'({mdc, mdio_oe}), 64'd0);

        for (int i = 0; i < 32; i++) begin
            txn(i[0], 5'(i), 5'((i * 7 + 3) & 31), 16'hA5C3 ^ 16'(i * 16'h1111),
                16'h8001 ^ 16'(i * 16'h0B0D), (i % 8) == 3);
        end
        txn(1'b0, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 1'b0);
        txn(1'b1, 5'd0, 5'd0, 16'h0000, 16'h0000, 1'b1);
        txn(1'b1, 5'd31, 5'd0, 16'hFFFF, 16'h0000, 1'b0);
        txn(1'b0, 5'd0, 5'd31, 16'h0000, 16'h0000, 1'b1);

        chk("R3 line steady while clock high", 64'(hold_viol), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule